// File: doc/BRIEF.md
# Pointer Register Addressing Unit

This block keeps three 16-bit pointer registers (indices 0, 1 and 2, called X, Y and Z) and turns an indirect memory request into an effective address. A request names a pointer and an addressing mode: plain, post-increment, pre-decrement or displacement. A separate flag marks a program-memory read, which always goes through Z. The block computes the address. When the mode changes the pointer, it writes the new value back in the cycle the request is accepted. It returns the address and the pointer's new value as a response.

Requests and responses are valid/ready streams, and the block holds one request at a time. `req_ready` is high only when the block is idle. Once a request is accepted, `req_ready` stays low until the response has been taken, so a consumer that holds `resp_ready` low stalls the request side. A held response does not change. A plain load port (`ld_en`, `ld_sel`, `ld_data`) lets the register file write a pointer directly. All three pointer values are always visible on outputs.

Top module: `ptr_addr_unit`

## Requirements
- R1: After reset all three pointers read 0, `resp_valid` is 0 and `req_ready` is 1.
- R2: Plain mode (`req_mode`=0) returns the pointer value as the address and leaves every pointer unchanged.
- R3: Post-increment mode (`req_mode`=1) returns the old pointer value as the address and writes pointer+1 back, wrapping 0xFFFF to 0x0000.
- R4: Pre-decrement mode (`req_mode`=2) returns pointer-1 as the address and writes that value back, wrapping 0x0000 to 0xFFFF.
- R5: Displacement mode (`req_mode`=3) on Y (`req_sel`=1) or Z (`req_sel`=2) returns pointer + q as the address, where q is the unsigned 6-bit `req_disp`. The sum wraps modulo 2^16 and the pointer is not changed.
- R6: Displacement mode on X (`req_sel`=0), or `req_sel`=3 without `req_prog`, gives `resp_illegal`=1 with `resp_addr`=0 and `resp_ptr`=0, and leaves every pointer unchanged.
- R7: With `req_prog`=1, Z is used whatever `req_sel` says. Plain and post-increment behave as in R2 and R3. Pre-decrement and displacement are illegal as in R6. `resp_prog` echoes the flag.
- R8: When a request is accepted at clock edge n, `resp_valid` first reads 1 after edge n+1 for a data access (2 cycles) and after edge n+2 for a program-memory read (3 cycles).
- R9: `req_ready` stays 0 from acceptance until the response handshake. While `resp_valid`=1 and `resp_ready`=0, all response outputs hold steady, and requests offered in that time are not taken.
- R10: A pointer write-back is visible on `ptr_x`/`ptr_y`/`ptr_z` after the accepting edge. `ld_en` writes `ld_data` into pointer `ld_sel`. If an accepted request writes back to the same pointer in the same cycle, the write-back wins.
- R11: `resp_ptr` carries the selected pointer's value after the request: the updated value for R3 and R4, and the unchanged value for R2 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_sel | input | 2 | Pointer: 0 X, 1 Y, 2 Z, 3 reserved |
| req_mode | input | 2 | 0 plain, 1 post-inc, 2 pre-dec, 3 displacement |
| req_disp | input | 6 | Unsigned displacement q |
| req_prog | input | 1 | Program-memory read through Z |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | Consumer takes response |
| resp_addr | output | 16 | Effective address |
| resp_ptr | output | 16 | Pointer value after the request |
| resp_illegal | output | 1 | Request was illegal |
| resp_prog | output | 1 | Response belongs to a program read |
| ld_en | input | 1 | Direct pointer write |
| ld_sel | input | 2 | Pointer index for the direct write |
| ld_data | input | 16 | Value for the direct write |
| ptr_x | output | 16 | Current X |
| ptr_y | output | 16 | Current Y |
| ptr_z | output | 16 | Current Z |

## Verification
The assertions that compare pointers across an accepted request assume no `ld_en` is aimed at the same register in that cycle, and they leave such cycles out. The response-hold check assumes the consumer does not depend on changes while it stalls. The bench drives every input on the falling edge and holds `req_valid` only until acceptance. It issues direct loads only when it means to test the load path, including one deliberate same-cycle collision.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
  typedef enum logic [1:0] {
    SEL_X   = 2'd0,
    SEL_Y   = 2'd1,
    SEL_Z   = 2'd2,
    SEL_RSV = 2'd3
  } ptr_sel_e;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_DISP    = 2'd3
  } amode_e;

  typedef struct packed {
    logic       illegal;
    logic       wr_en;
    logic [1:0] idx;
    amode_e     mode;
  } dec_t;
endpackage

// File: rtl/ptr_mode_decode.sv
module ptr_mode_decode
  import ptr_addr_pkg::*;
(
  input  logic [1:0] sel,
  input  logic [1:0] mode,
  input  logic       prog,
  output dec_t       dec
);
  amode_e m;
  logic   bad_data;
  logic   bad_prog;

  always_comb begin
    m        = amode_e'(mode);
    bad_data = (ptr_sel_e'(sel) == SEL_RSV) ||
               ((ptr_sel_e'(sel) == SEL_X) && (m == AM_DISP));
    bad_prog = (m == AM_PREDEC) || (m == AM_DISP);
    dec.mode    = m;
    dec.idx     = prog ? 2'(SEL_Z) : sel;
    dec.illegal = prog ? bad_prog : bad_data;
    dec.wr_en   = !dec.illegal && ((m == AM_POSTINC) || (m == AM_PREDEC));
  end
endmodule

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc
  import ptr_addr_pkg::*;
#(
  parameter int W      = 16,
  parameter int DISP_W = 6
) (
  input  logic [W-1:0]      base,
  input  amode_e            mode,
  input  logic [DISP_W-1:0] disp,
  output logic [W-1:0]      addr,
  output logic [W-1:0]      next
);
  logic [W-1:0] inc_v;
  logic [W-1:0] dec_v;
  logic [W-1:0] off_v;

  always_comb begin
    inc_v = base + W'(1);
    dec_v = base - W'(1);
    off_v = base + W'(disp);
    unique case (mode)
      AM_POSTINC: begin addr = base;  next = inc_v; end
      AM_PREDEC:  begin addr = dec_v; next = dec_v; end
      AM_DISP:    begin addr = off_v; next = base;  end
      default:    begin addr = base;  next = base;  end
    endcase
  end
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int W     = 16,
  parameter int NPTR  = 3,
  parameter int IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en,
  input  logic [IDX_W-1:0]     ld_idx,
  input  logic [W-1:0]         ld_data,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [W-1:0]         wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [W-1:0]         rd_data,
  output logic [NPTR-1:0][W-1:0] q
);
  for (genvar i = 0; i < NPTR; i++) begin : g_reg
    logic hit_wr;
    logic hit_ld;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(i));
    assign hit_ld = ld_en && (ld_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= '0;
      else if (hit_wr) q[i] <= wr_data;
      else if (hit_ld) q[i] <= ld_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NPTR; i++)
      if (rd_idx == IDX_W'(i)) rd_data = q[i];
  end
endmodule

// File: rtl/ptr_resp_ctl.sv
module ptr_resp_ctl #(
  parameter int W        = 16,
  parameter int DATA_LAT = 2,
  parameter int PROG_LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  output logic         acc,
  input  logic [W-1:0] cap_addr,
  input  logic [W-1:0] cap_ptr,
  input  logic         cap_ill,
  input  logic         cap_prog,
  output logic         resp_valid,
  input  logic         resp_ready,
  output logic [W-1:0] resp_addr,
  output logic [W-1:0] resp_ptr,
  output logic         resp_illegal,
  output logic         resp_prog
);
  localparam int MAX_LAT = (DATA_LAT > PROG_LAT) ? DATA_LAT : PROG_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT) + 1;

  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign req_ready = !busy;
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; resp_valid <= 1'b0;
      resp_addr <= '0; resp_ptr <= '0; resp_illegal <= 1'b0; resp_prog <= 1'b0;
    end else if (acc) begin
      busy         <= 1'b1;
      cnt          <= cap_prog ? CNT_W'(PROG_LAT - 1) : CNT_W'(DATA_LAT - 1);
      resp_addr    <= cap_addr;
      resp_ptr     <= cap_ptr;
      resp_illegal <= cap_ill;
      resp_prog    <= cap_prog;
    end else if (busy && !resp_valid) begin
      if (cnt <= CNT_W'(1)) resp_valid <= 1'b1;
      else                  cnt <= cnt - CNT_W'(1);
    end else if (resp_valid && resp_ready) begin
      resp_valid <= 1'b0;
      busy       <= 1'b0;
    end
  end

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_addr) &&
      $stable(resp_ptr) && $stable(resp_illegal) && $stable(resp_prog)));
  // R9
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !(resp_valid && resp_ready)) |=> !req_ready);
  // R8
  min_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !resp_valid);
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
  import ptr_addr_pkg::*;
#(
  parameter int W        = 16,
  parameter int DISP_W   = 6,
  parameter int NPTR     = 3,
  parameter int DATA_LAT = 2,
  parameter int PROG_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_sel,
  input  logic [1:0]        req_mode,
  input  logic [DISP_W-1:0] req_disp,
  input  logic              req_prog,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [W-1:0]      resp_addr,
  output logic [W-1:0]      resp_ptr,
  output logic              resp_illegal,
  output logic              resp_prog,
  input  logic              ld_en,
  input  logic [1:0]        ld_sel,
  input  logic [W-1:0]      ld_data,
  output logic [W-1:0]      ptr_x,
  output logic [W-1:0]      ptr_y,
  output logic [W-1:0]      ptr_z
);
  localparam int IDX_W = 2;

  dec_t                   dec;
  logic                   acc;
  logic [W-1:0]           base;
  logic [W-1:0]           ea;
  logic [W-1:0]           nxt;
  logic [NPTR-1:0][W-1:0] regs;

  ptr_mode_decode u_dec (
    .sel(req_sel), .mode(req_mode), .prog(req_prog), .dec(dec)
  );

  ptr_bank #(.W(W), .NPTR(NPTR), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_idx(ld_sel), .ld_data(ld_data),
    .wr_en(acc && dec.wr_en), .wr_idx(dec.idx), .wr_data(nxt),
    .rd_idx(dec.idx), .rd_data(base), .q(regs)
  );

  ptr_addr_calc #(.W(W), .DISP_W(DISP_W)) u_calc (
    .base(base), .mode(dec.mode), .disp(req_disp), .addr(ea), .next(nxt)
  );

  ptr_resp_ctl #(.W(W), .DATA_LAT(DATA_LAT), .PROG_LAT(PROG_LAT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .acc(acc),
    .cap_addr(dec.illegal ? '0 : ea), .cap_ptr(dec.illegal ? '0 : nxt),
    .cap_ill(dec.illegal), .cap_prog(req_prog),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_addr(resp_addr), .resp_ptr(resp_ptr),
    .resp_illegal(resp_illegal), .resp_prog(resp_prog)
  );

  assign ptr_x = regs[0];
  assign ptr_y = regs[1];
  assign ptr_z = regs[2];

  // R6
  illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dec.illegal && !ld_en) |=> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));
  // R2
  plain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !dec.illegal && !ld_en && (dec.mode == AM_PLAIN || dec.mode == AM_DISP))
      |=> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));
  // R3
  postinc_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dec.wr_en && dec.mode == AM_POSTINC) |=> (resp_ptr == resp_addr + W'(1)));
  // R4
  predec_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dec.wr_en && dec.mode == AM_PREDEC) |=> (resp_ptr == resp_addr));
endmodule

// File: tb/test_ptr_addr_unit.sv
module test_ptr_addr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_prog = 0, resp_ready = 0, ld_en = 0;
  logic [1:0] req_sel = 0, req_mode = 0, ld_sel = 0;
  logic [5:0] req_disp = 0;
  logic [15:0] ld_data = 0;
  logic req_ready, resp_valid, resp_illegal, resp_prog;
  logic [15:0] resp_addr, resp_ptr, ptr_x, ptr_y, ptr_z;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ptr_addr_unit i_ptr_addr_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_mode(req_mode), .req_disp(req_disp), .req_prog(req_prog),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_addr(resp_addr),
    .resp_ptr(resp_ptr), .resp_illegal(resp_illegal), .resp_prog(resp_prog),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_ptrs(input string tag, input logic [15:0] x, y, z);
    chk({tag, " X"}, ptr_x, x);
    chk({tag, " Y"}, ptr_y, y);
    chk({tag, " Z"}, ptr_z, z);
  endtask

  task automatic load(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    ld_en = 1; ld_sel = s; ld_data = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic do_req(input logic [1:0] s, m, input logic [5:0] q, input logic p,
                        output logic [15:0] a, pt, output logic il, pg, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_sel = s; req_mode = m; req_disp = q; req_prog = p;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!resp_valid && lat < 10) begin @(negedge clk); lat++; end
    a = resp_addr; pt = resp_ptr; il = resp_illegal; pg = resp_prog;
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
  endtask

  logic [15:0] a, pt;
  logic il, pg;
  int lat;

  task automatic t_reset();
    chk_ptrs("R1 reset", 16'h0, 16'h0, 16'h0);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_load();
    load(2'd0, 16'h1000); load(2'd1, 16'h2000); load(2'd2, 16'hFFFF);
    chk_ptrs("R10 load", 16'h1000, 16'h2000, 16'hFFFF);
  endtask

  task automatic t_plain();
    do_req(2'd0, 2'd0, 6'd5, 0, a, pt, il, pg, lat);
    chk("R2 addr", a, 16'h1000);
    chk("R11 plain ptr", pt, 16'h1000);
    chk("R8 data latency", lat, 2);
    chk("R2 illegal", il, 0);
    chk_ptrs("R2 keep", 16'h1000, 16'h2000, 16'hFFFF);
  endtask

  task automatic t_postinc();
    do_req(2'd0, 2'd1, 6'd0, 0, a, pt, il, pg, lat);
    chk("R3 addr", a, 16'h1000);
    chk("R11 postinc ptr", pt, 16'h1001);
    do_req(2'd2, 2'd1, 6'd0, 0, a, pt, il, pg, lat);
    chk("R3 wrap addr", a, 16'hFFFF);
    chk("R3 wrap ptr", pt, 16'h0000);
    chk_ptrs("R3 regs", 16'h1001, 16'h2000, 16'h0000);
  endtask

  task automatic t_predec();
    do_req(2'd1, 2'd2, 6'd0, 0, a, pt, il, pg, lat);
    chk("R4 addr", a, 16'h1FFF);
    chk("R4 ptr", pt, 16'h1FFF);
    do_req(2'd2, 2'd2, 6'd0, 0, a, pt, il, pg, lat);
    chk("R4 wrap addr", a, 16'hFFFF);
    chk_ptrs("R4 regs", 16'h1001, 16'h1FFF, 16'hFFFF);
  endtask

  task automatic t_disp();
    do_req(2'd1, 2'd3, 6'd63, 0, a, pt, il, pg, lat);
    chk("R5 Y q=63", a, 16'h203E);
    chk("R11 disp ptr", pt, 16'h1FFF);
    load(2'd2, 16'hFFF0);
    do_req(2'd2, 2'd3, 6'h20, 0, a, pt, il, pg, lat);
    chk("R5 Z wrap", a, 16'h0010);
    do_req(2'd2, 2'd3, 6'd0, 0, a, pt, il, pg, lat);
    chk("R5 Z q=0", a, 16'hFFF0);
    chk_ptrs("R5 keep", 16'h1001, 16'h1FFF, 16'hFFF0);
  endtask

  task automatic t_illegal();
    do_req(2'd0, 2'd3, 6'd7, 0, a, pt, il, pg, lat);
    chk("R6 X disp flag", il, 1);
    chk("R6 X disp addr", a, 0);
    chk("R6 X disp ptr", pt, 0);
    do_req(2'd3, 2'd1, 6'd0, 0, a, pt, il, pg, lat);
    chk("R6 sel3 flag", il, 1);
    chk_ptrs("R6 keep", 16'h1001, 16'h1FFF, 16'hFFF0);
  endtask

  task automatic t_prog();
    do_req(2'd0, 2'd1, 6'd0, 1, a, pt, il, pg, lat);
    chk("R7 prog addr from Z", a, 16'hFFF0);
    chk("R7 prog ptr", pt, 16'hFFF1);
    chk("R7 prog echo", pg, 1);
    chk("R8 prog latency", lat, 3);
    do_req(2'd2, 2'd2, 6'd0, 1, a, pt, il, pg, lat);
    chk("R7 prog predec illegal", il, 1);
    do_req(2'd2, 2'd3, 6'd1, 1, a, pt, il, pg, lat);
    chk("R7 prog disp illegal", il, 1);
    chk_ptrs("R7 regs", 16'h1001, 16'h1FFF, 16'hFFF1);
  endtask

  task automatic t_backpressure();
    logic [15:0] hold_a;
    @(negedge clk);
    req_valid = 1; req_sel = 2'd1; req_mode = 2'd2; req_disp = 0; req_prog = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R9 ready low after accept", req_ready, 0);
    repeat (2) @(negedge clk);
    chk("R9 valid", resp_valid, 1);
    hold_a = resp_addr;
    chk("R4 stalled addr", hold_a, 16'h1FFE);
    req_valid = 1; req_sel = 2'd1; req_mode = 2'd1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 hold valid", resp_valid, 1);
      chk("R9 hold addr", resp_addr, hold_a);
      chk("R9 ready low", req_ready, 0);
    end
    req_valid = 0;
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
    chk("R9 ready back", req_ready, 1);
    chk("R9 no extra accept Y", ptr_y, 16'h1FFE);
  endtask

  task automatic t_conflict();
    @(negedge clk);
    req_valid = 1; req_sel = 2'd1; req_mode = 2'd1; req_prog = 0;
    ld_en = 1; ld_sel = 2'd1; ld_data = 16'h5555;
    @(negedge clk);
    req_valid = 0; ld_en = 0;
    chk("R10 writeback wins", ptr_y, 16'h1FFF);
    while (!resp_valid) @(negedge clk);
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
    load(2'd0, 16'hABCD);
    chk("R10 load X", ptr_x, 16'hABCD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_plain();
    t_postinc();
    t_predec();
    t_disp();
    t_illegal();
    t_prog();
    t_backpressure();
    t_conflict();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule